// File: doc/BRIEF.md
# Match-Channel Timer with Watchdog Channel

This block keeps one free-running up-counter and six compare channels behind a small synchronous register bus. Every channel holds a compare value; on the clock edge at which the counter equals that value, the channel latches a status flag. The interrupt output is raised while any flagged channel also has its enable bit set. Software can freeze a copy of the counter in a snapshot register, so it can read a stable value while the live counter keeps running.

Channel 5 can also guard the system. When the global arm bit is set and channel 5's interrupt enable is set, a compare hit on channel 5 produces a one-cycle reset-request pulse. Software keeps the system alive in three steps: it takes a snapshot, adds a timeout in ticks, and writes the sum to channel 5's compare register. The ticks left before expiry are always the compare value minus the counter, in wrap-around arithmetic. The counter width is a parameter of at most 32 bits. Register reads are zero-extended to 32 bits.

Top module: `mtimer_wdog`

## Requirements
- R1: The counter resets to 0 and advances by 1 on every clock. After the all-ones value it returns to 0. It reads at offset 0x00, and writes to 0x00 have no effect.
- R2: The compare register of channel i (i = 0..5) lives at offset 0x08 + 4*i. It stores the low CNT_W bits of the write data, reads them back zero-extended on the cycle after the write, resets to 0, and leaves the other channels untouched.
- R3: Status bit i at offset 0x2C (bits 5:0) is set on the edge at which the counter equals compare value i. Writing a 1 to a status bit clears it. If a hit and a clear land on the same edge, the bit stays set. After reset every compare value is 0 and matches the counter at 0, so all six bits set on the first edge.
- R4: Offset 0x24 bits 5:0 hold per-channel enables. `irq` is 1 exactly while some status bit and its enable bit are both 1, from the cycle after the register write that causes it.
- R5: Offset 0x28 bit 0 is the watchdog arm bit. It reads back, and all other bits of that offset read 0.
- R6: `rst_req` is 1 for exactly one cycle. That cycle follows the edge at which the counter equals compare value 5 while the arm bit and enable bit 5 are both 1, so the counter reads compare value 5 plus 1 during the pulse.
- R7: No reset request is produced when enable bit 5 is clear or the arm bit is clear. Status bit 5 still sets on the hit.
- R8: Writing data with bit 0 = 1 to offset 0x30 copies the counter value of that cycle into the snapshot at 0x34. Writing bit 0 = 0 leaves the snapshot unchanged. Offset 0x30 reads 0.
- R9: Rewriting compare value 5 before expiry moves the reset request to the new value. The old value then produces no pulse.
- R10: The following offsets are unmapped: 0x04, 0x20, 0x38 to 0xFC, and any address whose two low bits are not 00. Reads of them return 0, and writes to them change no state.
- R11: While `rst_n` is low (asynchronous), every register reads 0 and both `irq` and `rst_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances once per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wen | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Enabled-and-flagged interrupt output |
| rst_req | output | 1 | One-cycle system reset request from the watchdog channel |

## Verification
Read data depends combinationally on the current address and on registered state, so a value written on one edge is seen in the cycle after it. Status flags and the reset request come from registers loaded on the edge where counter and compare value are equal. They therefore appear one cycle after that equality, while the counter already reads the compare value plus one. `irq` follows status and enable combinationally. The bench drives the bus on falling edges and updates its behavioural model on rising edges. It compares read data, `irq` and `rst_req` with the model 3 ns after each falling edge. Directed probes sample 2 ns after the falling edge, so every sample falls in the cycle where the result is due.

// File: rtl/mtw_pkg.sv
package mtw_pkg;
  // Number of compare channels and the one that can guard the system.
  localparam int NCH   = 6;
  localparam int WD_CH = 5;

  // Byte address width of the register bus; registers are word aligned.
  localparam int AW  = 8;
  localparam int WIW = AW - 2;

  typedef logic [WIW-1:0] widx_t;

  // Word indices of the register map.
  localparam widx_t W_CNT    = widx_t'(0);
  localparam widx_t W_MATCH0 = widx_t'(2);
  localparam widx_t W_IEN    = widx_t'(9);
  localparam widx_t W_ARM    = widx_t'(10);
  localparam widx_t W_STAT   = widx_t'(11);
  localparam widx_t W_LCMD   = widx_t'(12);
  localparam widx_t W_SNAP   = widx_t'(13);

  // Ticks from count c up to compare value m, modulo 2**w.
  function automatic logic [31:0] f_gap(input logic [31:0] m,
                                        input logic [31:0] c,
                                        input int unsigned w);
    logic [32:0] msk;
    msk = (33'd1 << w) - 33'd1;
    return (m - c) & msk[31:0];
  endfunction

  // A channel hits when no ticks remain.
  function automatic logic f_hit(input logic [31:0] gap);
    return gap == 32'd0;
  endfunction
endpackage

// File: rtl/mtw_counter.sv
module mtw_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_req,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] snap_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      cnt_q <= cnt_q + ONE;
      if (latch_req) snap_q <= cnt_q;
    end
  end
endmodule

// File: rtl/mtw_channel.sv
module mtw_channel import mtw_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             clr,
  output logic [CNT_W-1:0] match_q,
  output logic [31:0]      gap,
  output logic             hit,
  output logic             stat_q
);
  assign gap = f_gap(32'(match_q), 32'(cnt), CNT_W);
  assign hit = f_hit(gap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      stat_q  <= 1'b0;
    end else begin
      if (wr_en) match_q <= wr_val;
      // A hit on the same edge as a clear keeps the flag.
      stat_q <= hit | (stat_q & ~clr);
    end
  end
endmodule

// File: rtl/mtw_regfile.sv
module mtw_regfile import mtw_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW-1:0]             addr,
  input  logic                      wen,
  input  logic [31:0]               wdata,
  input  logic [CNT_W-1:0]          cnt,
  input  logic [CNT_W-1:0]          snap,
  input  logic [NCH-1:0][CNT_W-1:0] match_all,
  input  logic [NCH-1:0]            stat,
  output logic [31:0]               rdata,
  output logic [NCH-1:0]            match_wr,
  output logic [CNT_W-1:0]          wr_val,
  output logic [NCH-1:0]            stat_clr,
  output logic                      latch_req,
  output logic [NCH-1:0]            ien_q,
  output logic                      arm_q
);
  logic  aligned;
  logic  wr_ok;
  widx_t widx;

  assign aligned = (addr[1:0] == 2'b00);
  assign widx    = addr[AW-1:2];
  assign wr_ok   = wen & aligned;
  assign wr_val  = wdata[CNT_W-1:0];

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_mwr
      assign match_wr[i] = wr_ok && (widx == widx_t'(W_MATCH0 + i));
    end
  endgenerate

  assign stat_clr  = (wr_ok && widx == W_STAT) ? wdata[NCH-1:0] : '0;
  assign latch_req = wr_ok && (widx == W_LCMD) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      arm_q <= 1'b0;
    end else if (wr_ok) begin
      if (widx == W_IEN) ien_q <= wdata[NCH-1:0];
      if (widx == W_ARM) arm_q <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      case (widx)
        W_CNT:   rdata = 32'(cnt);
        W_IEN:   rdata = 32'(ien_q);
        W_ARM:   rdata = {31'd0, arm_q};
        W_STAT:  rdata = 32'(stat);
        W_SNAP:  rdata = 32'(snap);
        default: rdata = '0;
      endcase
      for (int i = 0; i < NCH; i++) begin
        if (widx == widx_t'(W_MATCH0 + i)) rdata = 32'(match_all[i]);
      end
    end
  end
endmodule

// File: rtl/mtw_wdog.sv
module mtw_wdog (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_hit,
  input  logic arm,
  input  logic wd_ien,
  output logic rst_req
);
  // Counter leaves the compare value on the next edge, so this is one cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= wd_hit & arm & wd_ien;
  end
endmodule

// File: rtl/mtimer_wdog.sv
module mtimer_wdog import mtw_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wen,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  output logic          rst_req
);
  logic [CNT_W-1:0]          cnt_q;
  logic [CNT_W-1:0]          snap_q;
  logic                      latch_req;
  logic [NCH-1:0][CNT_W-1:0] match_all;
  logic [NCH-1:0][31:0]      gap_all;
  logic [NCH-1:0]            match_wr;
  logic [CNT_W-1:0]          wr_val;
  logic [NCH-1:0]            stat_clr;
  logic [NCH-1:0]            hit;
  logic [NCH-1:0]            stat;
  logic [NCH-1:0]            ien;
  logic                      arm;
  logic [31:0]               wd_gap;

  mtw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_req (latch_req),
    .cnt_q     (cnt_q),
    .snap_q    (snap_q)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      mtw_channel #(.CNT_W(CNT_W)) u_ch (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt_q),
        .wr_en   (match_wr[i]),
        .wr_val  (wr_val),
        .clr     (stat_clr[i]),
        .match_q (match_all[i]),
        .gap     (gap_all[i]),
        .hit     (hit[i]),
        .stat_q  (stat[i])
      );
    end
  endgenerate

  mtw_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (bus_addr),
    .wen       (bus_wen),
    .wdata     (bus_wdata),
    .cnt       (cnt_q),
    .snap      (snap_q),
    .match_all (match_all),
    .stat      (stat),
    .rdata     (bus_rdata),
    .match_wr  (match_wr),
    .wr_val    (wr_val),
    .stat_clr  (stat_clr),
    .latch_req (latch_req),
    .ien_q     (ien),
    .arm_q     (arm)
  );

  assign wd_gap = gap_all[WD_CH];

  mtw_wdog u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wd_hit  (hit[WD_CH]),
    .arm     (arm),
    .wd_ien  (ien[WD_CH]),
    .rst_req (rst_req)
  );

  assign irq = |(stat & ien);
endmodule

// File: rtl/mtw_checker.sv
module mtw_checker import mtw_pkg::*; #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] snap_q,
  input logic             latch_req,
  input logic [NCH-1:0]   hit,
  input logic [NCH-1:0]   stat,
  input logic [NCH-1:0]   ien,
  input logic             arm,
  input logic             irq,
  input logic             rst_req,
  input logic [31:0]      wd_gap
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cnt_q == $past(cnt_q) + ONE));

  a_r3_hit_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((stat & $past(hit)) == $past(hit)));

  a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((ien != '0) && (stat != '0)));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(wd_gap) == 32'd0 && $past(arm) && $past(ien[WD_CH])));

  a_r7_disabled_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien[WD_CH] || !arm) |=> !rst_req);

  a_r8_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    latch_req |=> (snap_q == $past(cnt_q)));
endmodule

bind mtimer_wdog mtw_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_q     (cnt_q),
  .snap_q    (snap_q),
  .latch_req (latch_req),
  .hit       (hit),
  .stat      (stat),
  .ien       (ien),
  .arm       (arm),
  .irq       (irq),
  .rst_req   (rst_req),
  .wd_gap    (wd_gap)
);

// File: tb/mtimer_wdog_test.sv
`timescale 1ns/1ps
module mtimer_wdog_test;
  localparam int TW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        rst_req;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic s_irq, s_rrq;

  always #4 clk = ~clk;

  mtimer_wdog #(.CNT_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
  );

  // Behavioural reference model.
  logic [15:0] m_cnt = 0, m_snap = 0;
  logic [15:0] m_match [6];
  logic [5:0]  m_ien = 0, m_stat = 0, m_hitv = 0, m_clrv = 0;
  logic        m_arm = 0, m_rreq = 0;

  initial for (int i = 0; i < 6; i++) m_match[i] = 16'h0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_snap = 0; m_ien = 0; m_arm = 0; m_stat = 0; m_rreq = 0;
      for (int i = 0; i < 6; i++) m_match[i] = 16'h0;
    end else begin
      m_hitv = 6'h0;
      for (int i = 0; i < 6; i++) if (m_cnt == m_match[i]) m_hitv[i] = 1'b1;
      m_clrv = (bus_wen && bus_addr == 8'h2C) ? bus_wdata[5:0] : 6'h0;
      m_rreq = m_hitv[5] && m_arm && m_ien[5];
      if (bus_wen) begin
        if (bus_addr >= 8'h08 && bus_addr <= 8'h1C && bus_addr[1:0] == 2'b00)
          m_match[(bus_addr - 8'h08) >> 2] = bus_wdata[15:0];
        if (bus_addr == 8'h24) m_ien = bus_wdata[5:0];
        if (bus_addr == 8'h28) m_arm = bus_wdata[0];
        if (bus_addr == 8'h30 && bus_wdata[0]) m_snap = m_cnt;
      end
      m_stat = (m_stat & ~m_clrv) | m_hitv;
      m_cnt  = m_cnt + 16'd1;
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a == 8'h00) return {16'h0, m_cnt};
    if (a >= 8'h08 && a <= 8'h1C) return {16'h0, m_match[(a - 8'h08) >> 2]};
    case (a)
      8'h24:   return {26'h0, m_ien};
      8'h28:   return {31'h0, m_arm};
      8'h2C:   return {26'h0, m_stat};
      8'h34:   return {16'h0, m_snap};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Every-cycle comparison, 1 ns before the rising edge.
  always @(negedge clk) begin
    #3;
    if (!done) begin
      check(bus_rdata === m_read(bus_addr), "R1 R2 R10 read-path model", bus_rdata, m_read(bus_addr));
      check(irq === (|(m_stat & m_ien)), "R4 irq model", {31'h0, irq}, {31'h0, |(m_stat & m_ien)});
      check(rst_req === m_rreq, "R6 R7 reset-request model", {31'h0, rst_req}, {31'h0, m_rreq});
    end
  end

  // Bus tasks: each starts and ends on a falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wen = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; bus_wen = 1'b0;
    #2;
    v = bus_rdata; s_irq = irq; s_rrq = rst_req;
    @(negedge clk);
  endtask

  task automatic poll(input int ncyc, output int npulse, output logic [15:0] at_cnt, output bit irq_seen);
    npulse = 0; at_cnt = 16'h0; irq_seen = 1'b0;
    bus_addr = 8'h00; bus_wen = 1'b0;
    for (int k = 0; k < ncyc; k++) begin
      #2;
      if (rst_req) begin
        npulse++;
        if (npulse == 1) at_cnt = bus_rdata[15:0];
      end
      if (irq) irq_seen = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  localparam logic [7:0] ZADDR [7] = '{8'h00, 8'h08, 8'h1C, 8'h24, 8'h28, 8'h2C, 8'h34};

  initial begin
    logic [31:0] v, w, s;
    logic [15:0] snap_l, at;
    int np;
    bit irqs;

    repeat (2) @(negedge clk);
    // R11: everything reads zero while reset is held.
    foreach (ZADDR[j]) begin
      rd(ZADDR[j], v);
      check(v == 32'h0, "R11 register zero in reset", v, 32'h0);
    end
    check(s_irq == 1'b0 && s_rrq == 1'b0, "R11 outputs low in reset", {s_irq, s_rrq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: all compare values 0 match the counter at 0 on the first edge.
    rd(8'h2C, v);
    check(v == 32'h3F, "R3 all channels hit at count zero", v, 32'h3F);

    // R1: one step per clock, writes to the counter ignored.
    rd(8'h00, v); rd(8'h00, w);
    check(w[15:0] == v[15:0] + 16'd1, "R1 counter step", w, v + 1);
    wr(8'h2C, 32'h3F);
    rd(8'h00, v); wr(8'h00, 32'h0); rd(8'h00, w);
    check(w[15:0] == v[15:0] + 16'd2, "R1 counter write ignored", w, v + 2);

    // R2: compare register readback and truncation.
    wr(8'h10, 32'h1234); rd(8'h10, v);
    check(v == 32'h1234, "R2 compare readback", v, 32'h1234);
    wr(8'h10, 32'hABCD5678); rd(8'h10, v);
    check(v == 32'h5678, "R2 upper bits dropped", v, 32'h5678);
    rd(8'h14, v);
    check(v == 32'h0, "R2 neighbour untouched", v, 32'h0);

    // R8 / R10: snapshot command and unmapped offsets.
    rd(8'h34, w);
    wr(8'h30, 32'h0); rd(8'h34, v);
    check(v == w, "R8 write of 0 takes no snapshot", v, w);
    wr(8'h20, 32'hFFFFFFFF); wr(8'h04, 32'hFFFFFFFF); wr(8'h11, 32'hFFFFFFFF);
    rd(8'h10, v);
    check(v == 32'h5678, "R10 misaligned write ignored", v, 32'h5678);
    rd(8'h20, v); check(v == 32'h0, "R10 offset 0x20 reads zero", v, 32'h0);
    rd(8'h04, v); check(v == 32'h0, "R10 offset 0x04 reads zero", v, 32'h0);
    rd(8'h3C, v); check(v == 32'h0, "R10 offset 0x3C reads zero", v, 32'h0);
    rd(8'h11, v); check(v == 32'h0, "R10 misaligned read zero", v, 32'h0);
    rd(8'h30, v); check(v == 32'h0, "R8 command offset reads zero", v, 32'h0);
    rd(8'h00, v); wr(8'h30, 32'h1); rd(8'h34, w);
    check(w[15:0] == v[15:0] + 16'd1, "R8 snapshot captures counter", w, v + 1);

    // R3: hit and clear on the same edge keep the flag; W1C clears it.
    rd(8'h00, v);
    wr(8'h0C, {16'h0, v[15:0] + 16'd3});
    @(negedge clk);
    wr(8'h2C, 32'h2);
    rd(8'h2C, s);
    check(s[1] == 1'b1, "R3 set wins over clear", s, 32'h2);
    // R4: enabling the flagged channel raises irq.
    check(s_irq == 1'b0, "R4 irq low with enables clear", {31'h0, s_irq}, 32'h0);
    wr(8'h24, 32'h2); rd(8'h2C, s);
    check(s_irq == 1'b1, "R4 irq high on enabled flag", {31'h0, s_irq}, 32'h1);
    wr(8'h2C, 32'h2); rd(8'h2C, s);
    check(s[1] == 1'b0, "R3 write-one clears", s, 32'h0);
    check(s_irq == 1'b0, "R4 irq drops after clear", {31'h0, s_irq}, 32'h0);

    // R5: arm bit readback.
    wr(8'h28, 32'hFFFFFFFE); rd(8'h28, v);
    check(v == 32'h0, "R5 only bit 0 stored", v, 32'h0);
    wr(8'h28, 32'h1); rd(8'h28, v);
    check(v == 32'h1, "R5 arm bit reads back", v, 32'h1);

    // R6: watchdog expiry after snapshot + 200 ticks.
    rd(8'h00, v); wr(8'h30, 32'h1);
    snap_l = v[15:0] + 16'd1;
    wr(8'h1C, {16'h0, snap_l + 16'd200});
    wr(8'h24, 32'h20);
    poll(400, np, at, irqs);
    check(np == 1, "R6 exactly one pulse cycle", np, 1);
    check(at == snap_l + 16'd201, "R6 pulse follows the match edge", {16'h0, at}, {16'h0, snap_l + 16'd201});

    // R9: restart moves the expiry.
    rd(8'h00, v); wr(8'h30, 32'h1);
    snap_l = v[15:0] + 16'd1;
    wr(8'h1C, {16'h0, snap_l + 16'd300});
    poll(150, np, at, irqs);
    check(np == 0, "R9 no pulse before expiry", np, 0);
    rd(8'h00, v); wr(8'h30, 32'h1);
    snap_l = v[15:0] + 16'd1;
    wr(8'h1C, {16'h0, snap_l + 16'd300});
    poll(500, np, at, irqs);
    check(np == 1, "R9 single pulse after restart", np, 1);
    check(at == snap_l + 16'd301, "R9 pulse at restarted value", {16'h0, at}, {16'h0, snap_l + 16'd301});

    // R7: enable bit 5 clear, arm set.
    wr(8'h24, 32'h0); wr(8'h2C, 32'h3F);
    rd(8'h00, v); wr(8'h1C, {16'h0, v[15:0] + 16'd40});
    poll(80, np, at, irqs);
    check(np == 0, "R7 no reset with enable clear", np, 0);
    rd(8'h2C, s);
    check(s[5] == 1'b1, "R7 status still sets", s, 32'h20);

    // R7: arm clear, enable bit 5 set.
    wr(8'h28, 32'h0); wr(8'h24, 32'h20); wr(8'h2C, 32'h3F);
    rd(8'h00, v); wr(8'h1C, {16'h0, v[15:0] + 16'd40});
    poll(80, np, at, irqs);
    check(np == 0, "R7 no reset with arm clear", np, 0);
    check(irqs == 1'b1, "R4 channel 5 interrupt without arm", {31'h0, irqs}, 32'h1);

    // R1: wrap from all-ones to zero.
    wr(8'h24, 32'h0);
    bus_addr = 8'h00;
    np = 0;
    for (int k = 0; k < 70000 && np == 0; k++) begin
      #2;
      if (bus_rdata[15:0] == 16'hFFFF) np = 1;
      @(negedge clk);
    end
    #2;
    check(np == 1 && bus_rdata == 32'h0, "R1 counter wraps to zero", bus_rdata, 32'h0);
    @(negedge clk);

    // R11: reset in the middle of operation.
    wr(8'h24, 32'h3F); wr(8'h28, 32'h1); wr(8'h30, 32'h1);
    rst_n = 1'b0;
    foreach (ZADDR[j]) begin
      rd(ZADDR[j], v);
      check(v == 32'h0, "R11 register cleared by reset", v, 32'h0);
    end
    check(s_irq == 1'b0 && s_rrq == 1'b0, "R11 outputs cleared by reset", {s_irq, s_rrq}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL all: watchdog expired, actual %0d cycles expected completion", 190000);
      summary();
      $finish;
    end
  end
endmodule